// File: doc/BRIEF.md
# CAN Controller Master Control Register

This block holds the master control word of a CAN controller. Software reads and writes it as one 32-bit word over a plain write strobe and data bus, and the current contents are always visible on the read bus. Most control fields are privileged: a write changes them only while the protection-enable input is high. A few fields are free to write at any time. Two fields act as strobes that clear themselves one cycle after they are set.

The register also runs the bus-off recovery handshake. A bus-off event from the protocol engine raises the configuration-request field, unless automatic bus-off recovery is selected. A recovery counter then watches sampled bus bits. Software may drop the configuration request only once 128 runs of 11 back-to-back recessive bits have been seen. A small timestamp counter is included, along with its two clear features: a full clear when a chosen mailbox completes, and a one-shot clear of its top bit. Outputs give the suspend behaviour, the set of usable mailboxes, a configuration-change-enable status and a soft-reset pulse.

Top module: `can_mctl`

## Requirements
- R1: After reset, rdata reads 0x0000_1000 (bit 12 set, all else zero), and cfg_ce is 0. cfg_ce becomes 1 on the first clock after reset is released.
- R2: rdata bits 31:17 always read 0, and writes to those bits have no effect.
- R3: Bit 16 (suspend-free) and bits 4:0 (mailbox select) take the written value on every write, whatever prot_en is. susp_free mirrors bit 16.
- R4: Bits 15, 13 and 11:6 take the written value only when prot_en is high in the write cycle. Otherwise they keep their old value.
- R5: Writing 1 to bit 14 with prot_en high makes bit 14 read 1 for exactly one cycle. On the clock edge where it returns to 0, the top bit of ts_value is cleared and the lower bits are kept.
- R6: While bit 15 is 1, a mb16_done pulse sets ts_value to 0 on the next edge, and this takes priority over the bit 14 clear. While bit 15 is 0, mb16_done has no effect.
- R7: mbox_en is all ones when bit 13 is 1. When bit 13 is 0, only its low 16 bits are ones.
- R8: A busoff_evt pulse while bit 7 is 0 sets bit 12 on the next edge, and it wins over a write that clears bit 12 in the same cycle. While bit 7 is 1, busoff_evt leaves bit 12 unchanged.
- R9: After a bus-off event with bit 7 clear, a protected write of 0 to bit 12 is ignored until 128 groups of 11 consecutive recessive bits have been counted. A bit is counted when bit_tick is high, and bus_rx=1 means recessive. A dominant bit restarts the current group. After the 128 groups, the same write clears bit 12.
- R10: Bit 5 (soft reset) can only be set, and only with prot_en high. It reads 1 for one cycle, and soft_rst_pulse is high in exactly that cycle.
- R11: cfg_ce equals the value bit 12 had one cycle earlier.
- R12: ts_value increases by one on each clock edge where ts_tick is high and no clear applies, wrapping modulo 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wdata | input | 32 | Write data |
| prot_en | input | 1 | Protection enable; unlocks privileged fields |
| rdata | output | 32 | Current register contents |
| busoff_evt | input | 1 | One-cycle pulse: node went bus-off |
| bit_tick | input | 1 | A bus bit was sampled this cycle |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| mb16_done | input | 1 | Pulse: mailbox 16 finished a transfer |
| ts_tick | input | 1 | Timestamp count enable |
| susp_free | output | 1 | 1: keep running in debug halt; 0: stop after current frame |
| cfg_ce | output | 1 | Configuration change enabled |
| mbox_en | output | MBOX_N | Usable-mailbox mask |
| soft_rst_pulse | output | 1 | One-cycle soft reset request |
| ts_value | output | TS_W | Timestamp counter |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a bus-off event arrives in the same cycle as a privileged write that clears the configuration request. The bench drives both in one cycle and expects the request to read 1 afterward. In the second, a mailbox-16 completion lands on the edge where the timestamp top-bit clear takes effect. The bench pulses the completion in the cycle right after the bit 14 write, with the counter's top bit set, and expects the counter to read zero rather than the value with only its top bit dropped.

// File: rtl/can_mctl_pkg.sv
package can_mctl_pkg;

    localparam int REG_W = 17;

    typedef struct packed {
        logic       suspend_free;   // 16
        logic       ts_clr_mb16;    // 15
        logic       ts_msb_clr;     // 14
        logic       ext_mode;       // 13
        logic       cfg_req;        // 12
        logic       pwr_dn;         // 11
        logic       byte_ord;       // 10
        logic       wake_bus;       // 9
        logic       data_rev;       // 8
        logic       auto_bo;        // 7
        logic       self_test;      // 6
        logic       soft_rst;       // 5
        logic [4:0] mbox_sel;       // 4:0
    } mctl_t;

    localparam logic [REG_W-1:0] OPEN_MASK = 17'h1001F;
    localparam logic [REG_W-1:0] PRIV_MASK = 17'h0AFC0;
    localparam logic [REG_W-1:0] RST_VAL   = 17'h01000;

    // New register value after a word write. clr_ok says whether the
    // configuration request may be dropped now.
    function automatic mctl_t apply_write(mctl_t cur, logic [REG_W-1:0] w,
                                          logic prot, logic clr_ok);
        logic [REG_W-1:0] v;
        v = cur;
        v = (v & ~OPEN_MASK) | (w & OPEN_MASK);
        if (prot) begin
            v = (v & ~PRIV_MASK) | (w & PRIV_MASK);
            v[14] = w[14];
            v[5]  = w[5];
            if (w[12])
                v[12] = 1'b1;
            else if (clr_ok)
                v[12] = 1'b0;
        end
        return mctl_t'(v);
    endfunction

endpackage

// File: rtl/can_mctl_busoff.sv
module can_mctl_busoff #(
    parameter int RUN_BITS  = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic leave,
    input  logic tick,
    input  logic rx,
    output logic active,
    output logic done
);
    localparam int RW = $clog2(RUN_BITS);
    localparam int GW = $clog2(RUN_COUNT + 1);

    logic [RW-1:0] run;
    logic [GW-1:0] grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            run    <= '0;
            grp    <= '0;
        end else if (start) begin
            active <= 1'b1;
            run    <= '0;
            grp    <= '0;
        end else begin
            if (leave)
                active <= 1'b0;
            if (active && tick) begin
                if (!rx)
                    run <= '0;
                else if (run == RW'(RUN_BITS - 1)) begin
                    run <= '0;
                    if (grp != GW'(RUN_COUNT))
                        grp <= grp + 1'b1;
                end else
                    run <= run + 1'b1;
            end
        end
    end

    assign done = active && (grp == GW'(RUN_COUNT));

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && grp == '0 && run == '0));

    // R9
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run < RW'(RUN_BITS));

endmodule

// File: rtl/can_mctl_ts.sv
module can_mctl_ts #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            clr_all,
    input  logic            clr_msb,
    output logic [TS_W-1:0] cnt
);
    logic [TS_W-1:0] base;

    assign base = cnt + TS_W'(tick);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr_all)
            cnt <= '0;
        else if (clr_msb)
            cnt <= {1'b0, base[TS_W-2:0]};
        else
            cnt <= base;
    end

    // R6
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (cnt == '0));

    // R5
    msb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_msb && !clr_all) |=> !cnt[TS_W-1]);

endmodule

// File: rtl/can_mctl.sv
module can_mctl
    import can_mctl_pkg::*;
#(
    parameter int TS_W      = 16,
    parameter int MBOX_N    = 32,
    parameter int RUN_BITS  = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              prot_en,
    output logic [31:0]       rdata,
    input  logic              busoff_evt,
    input  logic              bit_tick,
    input  logic              bus_rx,
    input  logic              mb16_done,
    input  logic              ts_tick,
    output logic              susp_free,
    output logic              cfg_ce,
    output logic [MBOX_N-1:0] mbox_en,
    output logic              soft_rst_pulse,
    output logic [TS_W-1:0]   ts_value
);
    localparam int COMPAT_N = 16;

    mctl_t r, nx;
    logic  bo_active, bo_done, bo_exit, clr_ok, clr_try;
    wire   unused_hi = ^wdata[31:REG_W];

    assign clr_ok  = !bo_active || bo_done;
    assign clr_try = wr_en && prot_en && !wdata[12];
    assign bo_exit = bo_active && bo_done && (r.auto_bo || clr_try);

    always_comb begin
        nx = r;
        nx.ts_msb_clr = 1'b0;
        nx.soft_rst   = 1'b0;
        if (wr_en)
            nx = apply_write(nx, wdata[REG_W-1:0], prot_en, clr_ok);
        if (busoff_evt && !r.auto_bo)
            nx.cfg_req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r      <= mctl_t'(RST_VAL);
            cfg_ce <= 1'b0;
        end else begin
            r      <= nx;
            cfg_ce <= r.cfg_req;
        end
    end

    can_mctl_busoff #(.RUN_BITS(RUN_BITS), .RUN_COUNT(RUN_COUNT)) bo_i (
        .clk(clk), .rst(rst), .start(busoff_evt), .leave(bo_exit),
        .tick(bit_tick), .rx(bus_rx), .active(bo_active), .done(bo_done)
    );

    can_mctl_ts #(.TS_W(TS_W)) ts_i (
        .clk(clk), .rst(rst), .tick(ts_tick),
        .clr_all(mb16_done && r.ts_clr_mb16),
        .clr_msb(r.ts_msb_clr), .cnt(ts_value)
    );

    generate
        if (MBOX_N > COMPAT_N) begin : g_wide
            assign mbox_en = r.ext_mode ? {MBOX_N{1'b1}}
                           : {{(MBOX_N-COMPAT_N){1'b0}}, {COMPAT_N{1'b1}}};
        end else begin : g_narrow
            assign mbox_en = {MBOX_N{1'b1}};
        end
    endgenerate

    assign rdata          = {{(32-REG_W){1'b0}}, r};
    assign susp_free      = r.suspend_free;
    assign soft_rst_pulse = r.soft_rst;

    // R4
    priv_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !prot_en |=> ($stable(r.ts_clr_mb16) && $stable(r.ext_mode) &&
                      $stable(r.auto_bo) && $stable(r.pwr_dn) && $stable(r.self_test)));

    // R5
    tcc_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (r.ts_msb_clr && !(wr_en && prot_en && wdata[14])) |=> !r.ts_msb_clr);

    // R10
    soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst_pulse && !(wr_en && prot_en && wdata[5])) |=> !soft_rst_pulse);

    // R8
    busoff_set_chk: assert property (@(posedge clk) disable iff (rst)
        (busoff_evt && !r.auto_bo) |=> r.cfg_req);

    // R9
    cfg_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(r.cfg_req) |-> $past(!bo_active || bo_done));

endmodule

// File: tb/can_mctl_tb_top.sv
`timescale 1ns/1ps
module can_mctl_tb_top;
    localparam int TS_W = 6;
    localparam int MBOX_N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, prot_en = 1'b0;
    logic [31:0] wdata = '0;
    logic busoff_evt = 1'b0, bit_tick = 1'b0, bus_rx = 1'b1;
    logic mb16_done = 1'b0, ts_tick = 1'b0;
    logic [31:0] rdata;
    logic susp_free, cfg_ce, soft_rst_pulse;
    logic [MBOX_N-1:0] mbox_en;
    logic [TS_W-1:0] ts_value;

    int vecs = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    can_mctl #(.TS_W(TS_W), .MBOX_N(MBOX_N)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .prot_en(prot_en),
        .rdata(rdata), .busoff_evt(busoff_evt), .bit_tick(bit_tick),
        .bus_rx(bus_rx), .mb16_done(mb16_done), .ts_tick(ts_tick),
        .susp_free(susp_free), .cfg_ce(cfg_ce), .mbox_en(mbox_en),
        .soft_rst_pulse(soft_rst_pulse), .ts_value(ts_value)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [31:0] w, logic p);
        wr_en = 1'b1; wdata = w; prot_en = p;
        step();
        wr_en = 1'b0; wdata = '0; prot_en = 1'b0;
    endtask

    task automatic bits(int n, logic rx);
        bit_tick = 1'b1; bus_rx = rx;
        repeat (n) step();
        bit_tick = 1'b0; bus_rx = 1'b1;
    endtask

    task automatic ticks(int n);
        ts_tick = 1'b1;
        repeat (n) step();
        ts_tick = 1'b0;
    endtask

    // Expected register value after a write with no bus-off pending
    function automatic logic [16:0] model(logic [16:0] cur, logic [31:0] w, logic p);
        logic [16:0] v;
        v = cur;
        v[16]  = w[16];
        v[4:0] = w[4:0];
        if (p) begin
            v[15]   = w[15];
            v[14]   = w[14];
            v[13]   = w[13];
            v[12]   = w[12];
            v[11:6] = w[11:6];
            v[5]    = w[5];
        end
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [16:0] cur, nv;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata", rdata, 32'h0000_1000);
        check("R1 cfg_ce", {31'b0, cfg_ce}, 32'h0);
        check("R10 pulse idle", {31'b0, soft_rst_pulse}, 32'h0);
        check("R12 ts reset", {26'b0, ts_value}, 32'h0);
        check("R7 mask reset", mbox_en, 32'h0000_FFFF);
        step();
        check("R1 cfg_ce rise", {31'b0, cfg_ce}, 32'h1);

        // Sweep of write patterns and protection
        cur = 17'h01000;
        for (int i = 0; i < 96; i++) begin
            logic [31:0] w;
            logic p;
            w = (i * 32'h9E37_79B9) ^ (i << 13) ^ {i[3:0], 28'h0};
            p = (i % 3) != 0;
            nv = model(cur, w, p);
            wr(w, p);
            check("R2 reserved", {17'b0, rdata[31:17]}, 32'h0);
            check("R3/R4 readback", rdata, {15'b0, nv});
            check("R3 susp_free", {31'b0, susp_free}, {31'b0, nv[16]});
            check("R7 mask", mbox_en, nv[13] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
            check("R10 pulse", {31'b0, soft_rst_pulse}, {31'b0, nv[5]});
            check("R11 cfg_ce lag", {31'b0, cfg_ce}, {31'b0, cur[12]});
            step();
            cur = nv & ~17'h04020;
            check("R5/R10 self clear", rdata, {15'b0, cur});
            check("R11 cfg_ce", {31'b0, cfg_ce}, {31'b0, cur[12]});
        end

        // Timestamp features
        wr(32'h0000_9000, 1'b1);
        mb16_done = 1'b1; step(); mb16_done = 1'b0;
        check("R6 mbcc clear", {26'b0, ts_value}, 32'd0);
        ticks(40);
        check("R12 count", {26'b0, ts_value}, 32'd40);
        wr(32'h0000_D000, 1'b1);
        check("R5 tcc reads 1", rdata, 32'h0000_D000);
        check("R5 not yet", {26'b0, ts_value}, 32'd40);
        step();
        check("R5 msb cleared", {26'b0, ts_value}, 32'd8);
        check("R5 tcc back 0", rdata, 32'h0000_9000);
        ticks(40);
        check("R12 count2", {26'b0, ts_value}, 32'd48);
        wr(32'h0000_D000, 1'b1);
        mb16_done = 1'b1; step(); mb16_done = 1'b0;
        check("R6 priority", {26'b0, ts_value}, 32'd0);
        wr(32'h0000_1000, 1'b1);
        ticks(5);
        mb16_done = 1'b1; step(); mb16_done = 1'b0;
        check("R6 mbcc off", {26'b0, ts_value}, 32'd5);

        // Bus-off handling
        wr(32'h0, 1'b1);
        check("R9 clear idle", rdata, 32'h0);
        check("R11 lag", {31'b0, cfg_ce}, 32'h1);
        step();
        check("R11 drop", {31'b0, cfg_ce}, 32'h0);
        wr_en = 1'b1; wdata = 32'h0; prot_en = 1'b1; busoff_evt = 1'b1;
        step();
        wr_en = 1'b0; prot_en = 1'b0; busoff_evt = 1'b0;
        check("R8 evt wins", rdata, 32'h0000_1000);
        wr(32'h0, 1'b1);
        check("R9 blocked", rdata, 32'h0000_1000);
        bits(10, 1'b1);
        bits(1, 1'b0);
        bits(127 * 11, 1'b1);
        wr(32'h0, 1'b1);
        check("R9 blocked 127", rdata, 32'h0000_1000);
        bits(11, 1'b1);
        wr(32'h0, 1'b1);
        check("R9 released", rdata, 32'h0);
        wr(32'h0000_0080, 1'b1);
        busoff_evt = 1'b1; step(); busoff_evt = 1'b0;
        check("R8 auto kept", rdata, 32'h0000_0080);
        bits(128 * 11, 1'b1);
        check("R8 auto end", rdata, 32'h0000_0080);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule